// File: doc/BRIEF.md
# Byte-Addressed Data Memory with Per-Access Endianness

This block is a small synchronous data store in which every address selects one byte. A single request reads or writes an item of one, two, four or eight bytes. The item's address is its lowest byte address. A request input chooses, for that access alone, which end of the item holds its least significant byte. Write data and read data are both right-aligned in a 64-bit word. Read data is zero-extended above the item size.

The storage is split into eight byte-wide banks, one for each value of the low three address bits. An aligned item never crosses an eight-byte row, so each bank is touched at most once per access. A lane steering stage places the write bytes in the requested order. A gathering stage reorders the bank outputs on the way back. An address that is not a multiple of the item size is refused. The error flag rises in the cycle that would have carried the result, and a refused write leaves the storage untouched.

Top module: `endian_byte_mem`

## Requirements
- R1: The size input selects the item width: 2'b00 is one byte, 2'b01 is two bytes, 2'b10 is four bytes and 2'b11 is eight bytes. All four widths are supported at every aligned address, up to the top of the address space.
- R2: With `req_big` low, byte i of the item (bits 8i+7..8i of the value) is stored at address `req_addr`+i. The least significant byte therefore sits at the lowest address.
- R3: With `req_big` high, byte i of the item is stored at address `req_addr`+n-1-i, where n is the item size. The least significant byte therefore sits at the highest address.
- R4: A four-byte write of 0x01234567 at 0x100 leaves 01,23,45,67 at 0x100..0x103 in big-endian order, and 67,45,23,01 in little-endian order.
- R5: A valid request whose address is not a multiple of its item size sets `rsp_misalign` in the following cycle only. An aligned request or an idle cycle leaves it low in the following cycle.
- R6: A write refused as misaligned changes no byte of storage.
- R7: Read data appears one clock after the read request. Bits above the item size are zero.
- R8: A write changes exactly the bytes covered by the item and no others.
- R9: Storage contents are kept across reset.
- R10: The order is chosen per access. An item written in one order and read in the other comes back with its bytes reversed.
- R11: `rsp_rdata` is zero during and after reset, and in the cycle following a write, an idle cycle or a misaligned request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low; clears response registers only |
| req_vld | input | 1 | Request present this cycle |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the item's lowest byte |
| req_size | input | 2 | Item size code (see R1) |
| req_big | input | 1 | 1 = big-endian placement, 0 = little-endian |
| req_wdata | input | DATA_W | Right-aligned write value |
| rsp_rdata | output | DATA_W | Right-aligned, zero-extended read value, one cycle after the request |
| rsp_misalign | output | 1 | Misalignment error for the previous cycle's request |

## Verification
The hardest case to reach is a refused write that lands on bytes that already hold known values. From the outside it can only be told apart from an accepted write by reading those bytes afterwards. The stimulus therefore first fills a row with an eight-byte write and then sends a two-byte write at an odd address inside that row. It then reads the full row in both orders and checks that the contents are unchanged. A byte write with nonzero upper write data is also placed inside an already filled row. A full-row read after it shows that no other lane was touched.

// File: rtl/emem_pkg.sv
package emem_pkg;
   localparam int unsigned EMEM_LANES  = 8;
   localparam int unsigned EMEM_LANE_B = 3;
   localparam int unsigned EMEM_WORD_W = EMEM_LANES * 8;

   typedef enum logic [1:0] {
      EMEM_SZ_B = 2'b00,
      EMEM_SZ_H = 2'b01,
      EMEM_SZ_W = 2'b10,
      EMEM_SZ_D = 2'b11
   } emem_size_e;

   // number of bytes in an item of the given size (1..8)
   function automatic logic [3:0] emem_nbytes(input emem_size_e s);
      return 4'd1 << s;
   endfunction
endpackage

// File: rtl/emem_align_chk.sv
module emem_align_chk
   import emem_pkg::*;
(
   input  logic [EMEM_LANE_B-1:0] lo,
   input  emem_size_e             size,
   output logic                   misal
);
   logic [3:0]             nb;
   logic [EMEM_LANE_B-1:0] msk;

   assign nb    = emem_nbytes(size);
   // low-bit mask: 0 for bytes, 1 for halves, 3 for words, 7 for doubles
   assign msk   = nb[EMEM_LANE_B-1:0] - 3'd1;
   assign misal = |(lo & msk);
endmodule

// File: rtl/emem_wr_steer.sv
module emem_wr_steer
   import emem_pkg::*;
(
   input  logic [EMEM_LANE_B-1:0] lo,
   input  emem_size_e             size,
   input  logic                   big,
   input  logic [EMEM_WORD_W-1:0] wdata,
   output logic [EMEM_LANES-1:0]  lane_en,
   output logic [EMEM_WORD_W-1:0] lane_dat
);
   logic [3:0] nb;
   assign nb = emem_nbytes(size);

   for (genvar b = 0; b < EMEM_LANES; b++) begin : g_lane
      logic [3:0] off;
      logic [3:0] src;
      // position of this lane inside the item
      assign off = 4'(b) - {1'b0, lo};
      // which value byte lands here, depending on order
      assign src = big ? (nb - 4'd1 - off) : off;
      assign lane_en[b] = (4'(b) >= {1'b0, lo}) && (off < nb);
      assign lane_dat[8*b +: 8] = wdata[{src[2:0], 3'b000} +: 8];
   end
endmodule

// File: rtl/emem_rd_gather.sv
module emem_rd_gather
   import emem_pkg::*;
(
   input  logic                   active,
   input  logic [EMEM_LANE_B-1:0] lo,
   input  emem_size_e             size,
   input  logic                   big,
   input  logic [EMEM_WORD_W-1:0] lane_q,
   output logic [EMEM_WORD_W-1:0] rdata
);
   logic [3:0] nb;
   assign nb = emem_nbytes(size);

   for (genvar j = 0; j < EMEM_LANES; j++) begin : g_out
      logic [3:0]             src;
      logic [EMEM_LANE_B-1:0] lane;
      // item offset holding value byte j
      assign src  = big ? (nb - 4'd1 - 4'(j)) : 4'(j);
      assign lane = lo + src[2:0];
      assign rdata[8*j +: 8] = (active && (4'(j) < nb)) ?
                               lane_q[{lane, 3'b000} +: 8] : 8'h00;
   end
endmodule

// File: rtl/emem_bank.sv
module emem_bank #(
   parameter int unsigned ROW_W = 7
) (
   input  logic             clk,
   input  logic             we,
   input  logic [ROW_W-1:0] row,
   input  logic [7:0]       wd,
   output logic [7:0]       rd
);
   localparam int unsigned ROWS = 1 << ROW_W;

   logic [7:0] store [ROWS];

   always_ff @(posedge clk) begin
      if (we) store[row] <= wd;
      rd <= store[row];
   end
endmodule

// File: rtl/endian_byte_mem.sv
module endian_byte_mem
   import emem_pkg::*;
#(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic              req_big,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_misalign
);
   localparam int unsigned ROW_W = ADDR_W - EMEM_LANE_B;

   if (DATA_W != EMEM_WORD_W) begin : g_bad_data_w
      $error("endian_byte_mem: DATA_W must equal %0d", EMEM_WORD_W);
   end
   if (ADDR_W < EMEM_LANE_B + 1 || ADDR_W > 16) begin : g_bad_addr_w
      $error("endian_byte_mem: ADDR_W out of range 4..16");
   end

   logic [EMEM_LANE_B-1:0] lo;
   emem_size_e             sz;
   logic                   misal;
   logic [EMEM_LANES-1:0]  lane_en;
   logic [DATA_W-1:0]      lane_wd;
   logic [DATA_W-1:0]      lane_rd;
   logic                   wr_ok;

   assign lo    = req_addr[EMEM_LANE_B-1:0];
   assign sz    = emem_size_e'(req_size);
   assign wr_ok = req_vld & req_wr & ~misal;

   emem_align_chk u_align (
      .lo    (lo),
      .size  (sz),
      .misal (misal)
   );

   emem_wr_steer u_steer (
      .lo       (lo),
      .size     (sz),
      .big      (req_big),
      .wdata    (req_wdata),
      .lane_en  (lane_en),
      .lane_dat (lane_wd)
   );

   for (genvar b = 0; b < EMEM_LANES; b++) begin : g_bank
      emem_bank #(.ROW_W(ROW_W)) u_bank (
         .clk (clk),
         .we  (wr_ok & lane_en[b]),
         .row (req_addr[ADDR_W-1:EMEM_LANE_B]),
         .wd  (lane_wd[8*b +: 8]),
         .rd  (lane_rd[8*b +: 8])
      );
   end

   logic                   rd_act_q;
   logic                   err_q;
   logic [EMEM_LANE_B-1:0] lo_q;
   emem_size_e             sz_q;
   logic                   big_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_act_q <= 1'b0;
         err_q    <= 1'b0;
         lo_q     <= '0;
         sz_q     <= EMEM_SZ_B;
         big_q    <= 1'b0;
      end else begin
         rd_act_q <= req_vld & ~req_wr & ~misal;
         err_q    <= req_vld & misal;
         lo_q     <= lo;
         sz_q     <= sz;
         big_q    <= req_big;
      end
   end

   emem_rd_gather u_gather (
      .active (rd_act_q),
      .lo     (lo_q),
      .size   (sz_q),
      .big    (big_q),
      .lane_q (lane_rd),
      .rdata  (rsp_rdata)
   );

   assign rsp_misalign = err_q;
endmodule

// File: rtl/emem_checker.sv
module emem_checker #(
   parameter int unsigned ADDR_W = 10,
   parameter int unsigned DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_vld,
   input logic              req_wr,
   input logic [ADDR_W-1:0] req_addr,
   input logic [1:0]        req_size,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic              rsp_misalign
);
   logic odd_addr;
   always_comb begin
      case (req_size)
         2'b00:   odd_addr = 1'b0;
         2'b01:   odd_addr = req_addr[0];
         2'b10:   odd_addr = req_addr[1] | req_addr[0];
         default: odd_addr = req_addr[2] | req_addr[1] | req_addr[0];
      endcase
   end

   assert_flag_on_misalign_R5: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && odd_addr |=> rsp_misalign);

   assert_no_flag_when_aligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(req_vld && odd_addr) |=> !rsp_misalign);

   assert_byte_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !req_wr && req_size == 2'b00 |=> rsp_rdata[DATA_W-1:8] == '0);

   assert_half_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !req_wr && req_size == 2'b01 |=> rsp_rdata[DATA_W-1:16] == '0);

   assert_word_zero_ext_R7: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && !req_wr && req_size == 2'b10 |=> rsp_rdata[DATA_W-1:32] == '0);

   assert_quiet_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_vld && req_wr |=> rsp_rdata == '0);

   assert_quiet_on_error_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_misalign |-> rsp_rdata == '0);
endmodule

bind endian_byte_mem emem_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_emem_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .req_vld      (req_vld),
   .req_wr       (req_wr),
   .req_addr     (req_addr),
   .req_size     (req_size),
   .rsp_rdata    (rsp_rdata),
   .rsp_misalign (rsp_misalign)
);

// File: tb/endian_byte_mem_tb_top.sv
`timescale 1ns/1ps
module endian_byte_mem_tb_top;
   localparam int AW = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_vld = 1'b0;
   logic          req_wr = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = 2'b00;
   logic          req_big = 1'b0;
   logic [63:0]   req_wdata = '0;
   logic [63:0]   rsp_rdata;
   logic          rsp_misalign;

   always #10 clk = ~clk;

   endian_byte_mem #(.ADDR_W(AW), .DATA_W(64)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .req_wr(req_wr),
      .req_addr(req_addr), .req_size(req_size), .req_big(req_big),
      .req_wdata(req_wdata), .rsp_rdata(rsp_rdata), .rsp_misalign(rsp_misalign)
   );

   typedef struct {
      logic [63:0] rd;
      logic        err;
      string       tag;
   } exp_t;

   exp_t       sb_q[$];
   logic [7:0] ref_mem [0:(1<<AW)-1];
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // driver: one request per negedge, expected response queued
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [1:0] sz,
                         input bit big, input logic [63:0] wd, input string tag);
      exp_t e;
      int   n;
      @(negedge clk);
      req_vld = 1'b1; req_wr = wr; req_addr = a; req_size = sz;
      req_big = big;  req_wdata = wd;
      n = 1 << sz;
      e.rd = '0;
      e.err = (int'(a) % n) != 0;
      e.tag = tag;
      if (!e.err) begin
         for (int i = 0; i < n; i++) begin
            int loc;
            loc = big ? int'(a) + n - 1 - i : int'(a) + i;
            if (wr) ref_mem[loc] = wd[8*i +: 8];
            else    e.rd[8*i +: 8] = ref_mem[loc];
         end
      end
      sb_q.push_back(e);
   endtask

   task automatic idle(input string tag);
      exp_t e;
      @(negedge clk);
      req_vld = 1'b0; req_wr = 1'b0;
      e.rd = '0; e.err = 1'b0; e.tag = tag;
      sb_q.push_back(e);
   endtask

   task automatic drain();
      idle("R11 idle");
      idle("R11 idle");
      wait (sb_q.size() == 0);
   endtask

   // monitor: samples 5 ns after the edge
   always @(posedge clk) begin
      exp_t e;
      #5;
      if (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         chk(rsp_rdata, e.rd, {e.tag, " rdata"});
         chk({63'd0, rsp_misalign}, {63'd0, e.err}, {e.tag, " misalign"});
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      chk(rsp_rdata, 64'd0, "R11 reset rdata");
      chk({63'd0, rsp_misalign}, 64'd0, "R11 reset misalign");
      rst_n = 1'b1;

      // R3 R4: big-endian word at 0x100, read back bytewise
      access(1, 10'h100, 2'b10, 1, 64'h0000_0000_0123_4567, "R4 R3 be write");
      for (int k = 0; k < 4; k++)
         access(0, 10'(16'h100 + k), 2'b00, 0, '0, "R4 R3 be byte read");
      // R2 R4: little-endian word at 0x108
      access(1, 10'h108, 2'b10, 0, 64'h0000_0000_0123_4567, "R4 R2 le write");
      for (int k = 0; k < 4; k++)
         access(0, 10'(16'h108 + k), 2'b00, 1, '0, "R4 R2 le byte read");
      drain();
      // explicit byte values from R4
      access(0, 10'h100, 2'b00, 0, '0, "R4 byte 0x100");
      access(0, 10'h103, 2'b00, 0, '0, "R4 byte 0x103");
      access(0, 10'h108, 2'b00, 0, '0, "R4 byte 0x108");
      drain();
      chk({56'd0, ref_mem[10'h100]}, 64'h01, "R4 model 0x100");
      chk({56'd0, ref_mem[10'h108]}, 64'h67, "R4 model 0x108");

      // R10: order swap on read
      access(0, 10'h100, 2'b10, 1, '0, "R10 be read of be word");
      access(0, 10'h100, 2'b10, 0, '0, "R10 le read of be word");
      access(0, 10'h108, 2'b10, 1, '0, "R10 be read of le word");

      // R1: doubles and halves
      access(1, 10'h200, 2'b11, 0, 64'h1122_3344_5566_7788, "R1 dword le write");
      access(0, 10'h200, 2'b11, 1, '0, "R10 dword be read");
      access(0, 10'h200, 2'b11, 0, '0, "R1 dword le read");
      access(0, 10'h202, 2'b01, 0, '0, "R1 half le read");
      access(0, 10'h206, 2'b01, 1, '0, "R1 half be read");
      access(1, 10'h3F8, 2'b11, 1, 64'hA5A5_0F0F_C3C3_9966, "R1 top dword be write");
      access(0, 10'h3F8, 2'b11, 1, '0, "R1 top dword read");
      access(0, 10'h3FC, 2'b10, 0, '0, "R1 top word read");

      // R8 R7: byte write with upper garbage
      access(1, 10'h203, 2'b00, 1, 64'hFFFF_FFFF_FFFF_FFAA, "R8 byte write");
      access(0, 10'h200, 2'b11, 0, '0, "R8 neighbours kept");
      access(0, 10'h203, 2'b00, 0, '0, "R7 byte zero-extended");
      access(0, 10'h204, 2'b01, 1, '0, "R7 half zero-extended");

      // R5 R6: misaligned write refused
      access(1, 10'h201, 2'b01, 0, 64'h0000_0000_0000_BEEF, "R5 R6 odd half write");
      access(0, 10'h200, 2'b11, 0, '0, "R6 row unchanged le");
      access(0, 10'h200, 2'b11, 1, '0, "R6 row unchanged be");
      access(1, 10'h204, 2'b11, 0, 64'hDEAD_BEEF_DEAD_BEEF, "R5 R6 odd dword write");
      access(0, 10'h200, 2'b11, 0, '0, "R6 after odd dword");
      access(0, 10'h102, 2'b10, 0, '0, "R5 R11 odd word read");
      access(0, 10'h100, 2'b10, 0, '0, "R5 aligned after error");
      idle("R5 flag single cycle");
      drain();

      // R9: contents survive reset
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(rsp_rdata, 64'd0, "R11 rdata in reset");
      chk({63'd0, rsp_misalign}, 64'd0, "R11 misalign in reset");
      rst_n = 1'b1;
      access(0, 10'h100, 2'b10, 1, '0, "R9 word after reset");
      access(0, 10'h200, 2'b11, 0, '0, "R9 dword after reset");
      drain();

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule